// File: doc/BRIEF.md
# Dual-Channel Output Formatter and Multiplexer

This block takes matched pairs of 10-bit offset-binary samples from two converter channels, I and Q, which share one sample strobe. It recodes each sample as straight binary or two's complement and steers the words onto two output buses. In parallel mode each channel drives its own bus in the same cycle. In interleaved mode both channels share the I bus, I word first and Q word on the following cycle, and the Q bus is driven low.

The format and bus controls are static inputs. They are sampled only when a new pair is accepted, so a pair is never split across two configurations. A channel flag goes high while a Q word is on the I bus. The strobe accompanies every output word.

Top module: `dual_fmt_mux`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next cycle shows `bus_i`, `bus_q`, `out_vld` and `out_chq` all zero.
- R2: With `fmt_twos` low, an output word equals the input sample: 10'h3FF stays 10'h3FF, midscale 10'h200 stays 10'h200, 10'h000 stays 10'h000.
- R3: With `fmt_twos` high, bit 9 of the word is inverted and bits 8..0 are copied: 10'h200 becomes 10'h000, 10'h3FF becomes 10'h1FF, 10'h000 becomes 10'h200.
- R4: With `bus_par` high, one cycle after an accepted strobe `bus_i` holds the I word, `bus_q` holds the Q word, `out_vld` is 1 and `out_chq` is 0.
- R5: With `bus_par` low, one cycle after an accepted strobe `bus_i` holds the I word with `out_chq`=0, and the next cycle it holds the Q word with `out_chq`=1; `out_vld` is 1 in both cycles.
- R6: From the first output cycle of an interleaved pair, `bus_q` is all zeros.
- R7: `fmt_twos` and `bus_par` are sampled only with an accepted strobe; a change during the Q slot alters neither the Q word nor the bus steering of that pair.
- R8: A strobe arriving in the cycle before the Q slot (the cycle after an interleaved pair is accepted) is ignored: the Q word of the pending pair is output and the new pair never appears.
- R9: In a cycle with no accepted strobe and no pending Q word, `out_vld` and `out_chq` are 0 and both buses keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_vld | input | 1 | Sample pair strobe |
| smp_i | input | 10 | I sample, offset binary |
| smp_q | input | 10 | Q sample, offset binary |
| fmt_twos | input | 1 | 1 = two's complement, 0 = straight binary |
| bus_par | input | 1 | 1 = parallel buses, 0 = interleaved on I bus |
| bus_i | output | 10 | I output bus |
| bus_q | output | 10 | Q output bus |
| out_vld | output | 1 | Output word valid |
| out_chq | output | 1 | High while a Q word is on the I bus |

## Verification
The assertions take the inputs as stable, known values at each rising edge. They take as given that the latched bus mode only changes with an accepted strobe, and they do not assume that strobes are spaced, because a strobe during the Q slot has a defined result (it is dropped). The stimulus drives inputs only on falling edges. It mixes back-to-back strobes, strobes during the Q slot and control changes in the middle of a pair, so that the dropped-strobe and mid-pair rules are reached rather than avoided.

// File: rtl/dfm_pkg.sv
// Shared definitions for the dual-channel output formatter.
// Assumes: two channels, indexed I then Q.
package dfm_pkg;
    localparam int CH_N = 2;
    typedef enum logic {CH_I = 1'b0, CH_Q = 1'b1} chan_e;
endpackage

// File: rtl/dfm_code_fmt.sv
// Recodes one offset-binary sample as straight binary or two's complement.
// Assumes: input is offset binary with midscale at the top-bit-only code.
module dfm_code_fmt #(
    parameter int DW = 10
) (
    input  logic [DW-1:0] raw,
    input  logic          twos,
    output logic [DW-1:0] word
);
    // Flip only the sign bit when two's complement is selected.
    always_comb begin
        word         = raw;
        word[DW-1]   = raw[DW-1] ^ twos;
    end
endmodule

// File: rtl/dfm_slot_ctl.sv
// Decides pair acceptance and tracks the pending Q slot of an interleaved pair.
// Assumes: at most one Q word is ever pending; strobes during it are dropped.
module dfm_slot_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic par_mode,
    output logic accept,
    output logic q_slot
);
    logic q_pend;

    // A pair is accepted only when no Q word is waiting.
    always_comb accept = strobe && !q_pend;

    // Arm the Q slot for one cycle after an interleaved pair is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) q_pend <= 1'b0;
        else        q_pend <= accept && !par_mode;
    end

    assign q_slot = q_pend;

    // R5: a Q slot lasts exactly one cycle.
    p_single_qslot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        q_pend |=> !q_pend);
endmodule

// File: rtl/dual_fmt_mux.sv
// Output formatter and bus multiplexer for a matched I/Q sample pair.
// Assumes: smp_i/smp_q are offset binary and valid with smp_vld; the
// controls are sampled only when a pair is accepted.
module dual_fmt_mux #(
    parameter int DW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_vld,
    input  logic [DW-1:0] smp_i,
    input  logic [DW-1:0] smp_q,
    input  logic          fmt_twos,
    input  logic          bus_par,
    output logic [DW-1:0] bus_i,
    output logic [DW-1:0] bus_q,
    output logic          out_vld,
    output logic          out_chq
);
    import dfm_pkg::*;

    localparam logic [DW-1:0] ZERO_W = '0;

    logic [DW-1:0] raw_w  [CH_N];
    logic [DW-1:0] fmt_w  [CH_N];
    logic [DW-1:0] q_hold;
    logic          accept;
    logic          q_slot;
    logic          cfg_par;
    chan_e         cur_ch;

    assign raw_w[CH_I] = smp_i;
    assign raw_w[CH_Q] = smp_q;

    // One recoder per channel, both driven by the live format select.
    for (genvar c = 0; c < CH_N; c++) begin : g_ch
        dfm_code_fmt #(.DW(DW)) u_fmt (
            .raw  (raw_w[c]),
            .twos (fmt_twos),
            .word (fmt_w[c])
        );
    end

    dfm_slot_ctl u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe   (smp_vld),
        .par_mode (bus_par),
        .accept   (accept),
        .q_slot   (q_slot)
    );

    // Output registers: load a new pair, emit a pending Q word, or idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_i   <= ZERO_W;
            bus_q   <= ZERO_W;
            q_hold  <= ZERO_W;
            out_vld <= 1'b0;
            cur_ch  <= CH_I;
            cfg_par <= 1'b1;
        end else if (accept) begin
            bus_i   <= fmt_w[CH_I];
            bus_q   <= bus_par ? fmt_w[CH_Q] : ZERO_W;
            q_hold  <= fmt_w[CH_Q];
            out_vld <= 1'b1;
            cur_ch  <= CH_I;
            cfg_par <= bus_par;
        end else if (q_slot) begin
            bus_i   <= q_hold;
            out_vld <= 1'b1;
            cur_ch  <= CH_Q;
        end else begin
            out_vld <= 1'b0;
            cur_ch  <= CH_I;
        end
    end

    assign out_chq = (cur_ch == CH_Q);

    // R1: reset clears the outputs.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!out_vld && !out_chq && bus_i == ZERO_W && bus_q == ZERO_W));
    // R3: recoding never touches the bits below the sign bit.
    p_low_bits_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> bus_i[DW-2:0] == $past(smp_i[DW-2:0]));
    // R5: a Q word follows an I word of an interleaved pair.
    p_q_after_i_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_chq |-> (out_vld && $past(out_vld && !out_chq && !cfg_par)));
    // R6: the Q bus is low while interleaving.
    p_qbus_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && !cfg_par) |-> bus_q == ZERO_W);
    // R8: a pending Q slot wins over any new strobe.
    p_qslot_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        q_slot |=> out_chq);
    // R9: the channel flag only rides on valid words.
    p_flag_needs_vld_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_vld |-> !out_chq);
endmodule

// File: tb/dual_fmt_mux_tb.sv
`timescale 1ns/1ps
module dual_fmt_mux_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_vld = 1'b0;
    logic [9:0] smp_i = '0, smp_q = '0;
    logic       fmt_twos = 1'b0, bus_par = 1'b1;
    logic [9:0] bus_i, bus_q;
    logic       out_vld, out_chq;

    int errors = 0, checks = 0;
    bit done = 0;
    string tag = "R1";

    // reference model state
    int ei = 0, eq = 0, ev = 0, ec = 0;
    int pend[$];

    always #2.5 clk = ~clk;

    dual_fmt_mux u_dut (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_i(smp_i), .smp_q(smp_q),
        .fmt_twos(fmt_twos), .bus_par(bus_par), .bus_i(bus_i), .bus_q(bus_q),
        .out_vld(out_vld), .out_chq(out_chq)
    );

    function automatic int recode(int v, bit twos);
        return twos ? (v + 512) % 1024 : v;
    endfunction

    // behavioural reference, updated at each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            ei = 0; eq = 0; ev = 0; ec = 0; pend.delete();
        end else if (smp_vld && pend.size() == 0) begin
            ei = recode(int'(smp_i), fmt_twos);
            eq = bus_par ? recode(int'(smp_q), fmt_twos) : 0;
            if (!bus_par) pend.push_back(recode(int'(smp_q), fmt_twos));
            ev = 1; ec = 0;
        end else if (pend.size() != 0) begin
            ei = pend.pop_front(); ev = 1; ec = 1;
        end else begin
            ev = 0; ec = 0;
        end
    end

    task automatic chk(string t, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", t, what, act, exp);
        end
    endtask

    // compare every cycle on the falling edge
    always @(negedge clk) if (!done) begin
        chk(tag, "bus_i", int'(bus_i), ei);
        chk(tag, "bus_q", int'(bus_q), eq);
        chk(tag, "out_vld", int'(out_vld), ev);
        chk(tag, "out_chq", int'(out_chq), ec);
    end

    task automatic pair(int i, int q, bit tw, bit par);
        smp_vld = 1; smp_i = 10'(i); smp_q = 10'(q); fmt_twos = tw; bus_par = par;
        @(negedge clk);
        smp_vld = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        // R1 reset
        tag = "R1"; idle(3);
        chk("R1", "reset bus_i", int'(bus_i), 0);
        rst_n = 1;
        // R2 straight binary, parallel
        tag = "R2";
        pair('h3FF, 'h000, 0, 1);
        chk("R2", "full scale", int'(bus_i), 'h3FF);
        chk("R2", "neg full scale", int'(bus_q), 'h000);
        pair('h200, 'h155, 0, 1);
        chk("R2", "midscale", int'(bus_i), 'h200);
        // R3 two's complement
        tag = "R3";
        pair('h200, 'h3FF, 1, 1);
        chk("R3", "midscale", int'(bus_i), 'h000);
        chk("R3", "pos full", int'(bus_q), 'h1FF);
        pair('h000, 'h1AB, 1, 1);
        chk("R3", "neg full", int'(bus_i), 'h200);
        // R4 back-to-back parallel
        tag = "R4";
        pair('h011, 'h022, 0, 1);
        pair('h033, 'h044, 1, 1);
        chk("R4", "second pair q", int'(bus_q), 'h244);
        idle(2);
        // R5 / R6 interleaved
        tag = "R5";
        pair('h123, 'h321, 0, 0);
        chk("R6", "q bus low", int'(bus_q), 0);
        chk("R5", "i flag", int'(out_chq), 0);
        idle(1);
        chk("R5", "q word", int'(bus_i), 'h321);
        chk("R5", "q flag", int'(out_chq), 1);
        tag = "R6";
        pair('h0F0, 'h3C3, 1, 0);
        idle(2);
        // R7 controls change during the Q slot
        tag = "R7";
        pair('h2AA, 'h155, 0, 0);
        fmt_twos = 1; bus_par = 1;
        idle(1);
        chk("R7", "q word format kept", int'(bus_i), 'h155);
        chk("R7", "q bus still low", int'(bus_q), 0);
        idle(2);
        // R8 strobe during the Q slot is dropped
        tag = "R8";
        pair('h101, 'h202, 0, 0);
        pair('h3EE, 'h3DD, 0, 0);
        chk("R8", "pending q wins", int'(bus_i), 'h202);
        idle(1);
        chk("R8", "dropped pair absent", int'(out_vld), 0);
        // R9 idle holds buses
        tag = "R9";
        pair('h0AB, 'h0CD, 0, 1);
        idle(3);
        chk("R9", "hold bus_q", int'(bus_q), 'h0CD);
        // mixed stimulus
        tag = "R8";
        for (int k = 0; k < 400; k++) begin
            smp_vld = 1'($urandom);
            smp_i = 10'($urandom); smp_q = 10'($urandom);
            fmt_twos = 1'($urandom); bus_par = 1'($urandom);
            @(negedge clk);
        end
        smp_vld = 0;
        idle(3);
        finish_run();
    end
endmodule